// File: doc/BRIEF.md
# Scan-Line Counter and Vertical Row Divider

This block tracks which scan line of a display row is being drawn and decides when the vertical row counter moves on to the next row of video memory. A strobe that marks the end of each horizontal line advances a 4-bit scan counter. A 2-bit video mode selects how many scan lines are drawn from each row of memory: 2, 4, 8 or 16. Graphics modes use this to repeat each pixel row. Text modes use it to step through the rows of a character glyph.

In text modes the block also supplies the glyph row index used for font lookup. The 8-bit vertical row counter can be loaded from a data bus by the processor. This sets where the top of the screen falls in video memory, and stepping the loaded value between frames gives a smooth scroll. Sync and blanking are generated by software and are not part of this block.

Top module: `scan_row_divider`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the scan count, the row count, the glyph row and the advance output all read zero.
- R2: Each cycle with the line-end strobe high and no load raises the scan count by one on the next cycle, wrapping from 15 to 0. Cycles without the strobe leave the scan count unchanged.
- R3: In mode 00 (fine graphics), the advance output is high during a line-end strobe whenever scan bit 0 is one. The row therefore moves every 2 lines.
- R4: In mode 01 (coarse graphics), the advance output is high during a line-end strobe whenever scan bits 1..0 are both one. The row therefore moves every 4 lines.
- R5: In mode 10 (fine text), the advance output is high during a line-end strobe whenever scan bits 2..0 are all one. The glyph row is {0, scan[2:0]}.
- R6: In mode 11 (coarse text), the advance output is high during a line-end strobe whenever all four scan bits are one. The glyph row equals the full scan count.
- R7: In both graphics modes (00 and 01), the glyph row reads zero.
- R8: A cycle with the advance output high and no load raises the row count by one on the next cycle, wrapping from 255 to 0.
- R9: A cycle with the load input high sets the row count to the data bus and the scan count to zero on the next cycle. Load wins over a line-end strobe or an advance in the same cycle.
- R10: The advance output is never high in a cycle without the line-end strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_end_i | input | 1 | One-cycle strobe at the end of each horizontal line |
| mode_i | input | 2 | Video mode: 00 fine graphics, 01 coarse graphics, 10 fine text, 11 coarse text |
| row_load_i | input | 1 | Load the row counter from row_data_i and clear the scan count |
| row_data_i | input | 8 | New row counter value |
| scan_o | output | 4 | Current scan count |
| glyph_row_o | output | 4 | Font row index in text modes, zero in graphics modes |
| row_adv_o | output | 1 | Row counter count enable for this line end |
| row_o | output | 8 | Current vertical row counter |

## Verification
The bench runs each mode for a line count that is not a multiple of that mode's divisor. A design with a wrong divide boundary would therefore end on the wrong row or the wrong scan count.

Two runs start from rows 254 and 255, so a row counter that saturates or spills into a ninth bit lands on a value other than 0 or 2. One run goes past 16 lines to exercise the scan counter wrap.

Directed cases cover the following:
- A load in the same cycle as a line-end strobe, which catches an increment that wins over the load or a scan count that is not cleared.
- A strobe-free cycle with the scan bits all ones, which catches an advance that ignores the strobe.
- The glyph index in fine text mode, which catches a fourth scan bit leaking into the font row.

// File: rtl/scan_row_pkg.sv
package scan_row_pkg;
  typedef enum logic [1:0] {
    MODE_GFX_FINE   = 2'b00,
    MODE_GFX_COARSE = 2'b01,
    MODE_TXT_FINE   = 2'b10,
    MODE_TXT_COARSE = 2'b11
  } vmode_e;
endpackage

// File: rtl/scan_line_ctr.sv
module scan_line_ctr #(
  parameter int SCAN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clear_i,
  output logic [SCAN_W-1:0] scan_o
);
  logic [SCAN_W-1:0] scan_q, scan_d;
  logic              scan_en;

  always_comb begin
    scan_en = clear_i | step_i;
    scan_d  = clear_i ? '0 : scan_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      scan_q <= '0;
    else if (scan_en) scan_q <= scan_d;
  end

  assign scan_o = scan_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i) |=> scan_q == $past(scan_q) + 1'b1);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(scan_q));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> scan_q == '0);
endmodule

// File: rtl/row_step_decode.sv
module row_step_decode
  import scan_row_pkg::*;
#(
  parameter int SCAN_W = 4
) (
  input  logic              line_end_i,
  input  logic [1:0]        mode_i,
  input  logic [SCAN_W-1:0] scan_i,
  output logic              adv_o,
  output logic [SCAN_W-1:0] glyph_o
);
  logic [SCAN_W-1:0] low_mask;
  logic              is_text;
  logic              coarse;

  // Bits below the divide boundary: mode n checks the low n+1 scan bits.
  always_comb begin
    for (int i = 0; i < SCAN_W; i++) begin
      low_mask[i] = (i <= int'(mode_i));
    end
  end

  assign adv_o   = line_end_i & (&(scan_i | ~low_mask));
  assign is_text = mode_i[1];
  assign coarse  = (mode_i == MODE_TXT_COARSE);

  // Fine text drops the top scan bit from the font row.
  genvar g;
  generate
    for (g = 0; g < SCAN_W; g++) begin : g_glyph
      if (g == SCAN_W - 1) begin : g_top
        assign glyph_o[g] = is_text & coarse & scan_i[g];
      end else begin : g_low
        assign glyph_o[g] = is_text & scan_i[g];
      end
    end
  endgenerate
endmodule

// File: rtl/row_ctr.sv
module row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] data_i,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [ROW_W-1:0] ROW_MAX = '1;

  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;

  always_comb begin
    row_en = load_i | adv_i;
    row_d  = load_i ? data_i : row_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  assign row_o = row_q;

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> row_q == $past(data_i));
  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && row_q == ROW_MAX) |=> row_q == '0);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !load_i) |=> $stable(row_q));
endmodule

// File: rtl/scan_row_divider.sv
module scan_row_divider
  import scan_row_pkg::*;
#(
  parameter int SCAN_W = 4,
  parameter int ROW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic [1:0]        mode_i,
  input  logic              row_load_i,
  input  logic [ROW_W-1:0]  row_data_i,
  output logic [SCAN_W-1:0] scan_o,
  output logic [SCAN_W-1:0] glyph_row_o,
  output logic              row_adv_o,
  output logic [ROW_W-1:0]  row_o
);
  logic [SCAN_W-1:0] scan;
  logic              adv;

  scan_line_ctr #(.SCAN_W(SCAN_W)) u_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (line_end_i),
    .clear_i (row_load_i),
    .scan_o  (scan)
  );

  row_step_decode #(.SCAN_W(SCAN_W)) u_dec (
    .line_end_i (line_end_i),
    .mode_i     (mode_i),
    .scan_i     (scan),
    .adv_o      (adv),
    .glyph_o    (glyph_row_o)
  );

  row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (row_load_i),
    .data_i (row_data_i),
    .adv_i  (adv),
    .row_o  (row_o)
  );

  assign scan_o    = scan;
  assign row_adv_o = adv;

  p_strobe_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_adv_o |-> line_end_i);
  p_gfx_glyph_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |-> glyph_row_o == '0);
  p_fine_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_GFX_FINE && line_end_i && scan_o[0]) |-> row_adv_o);
  p_coarse_txt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TXT_COARSE && row_adv_o) |-> (&scan_o));
endmodule

// File: tb/tb_scan_row_divider.sv
module tb_scan_row_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       line_end_i;
  logic [1:0] mode_i;
  logic       row_load_i;
  logic [7:0] row_data_i;
  logic [3:0] scan_o, glyph_row_o;
  logic       row_adv_o;
  logic [7:0] row_o;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  scan_row_divider dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_end_i(line_end_i), .mode_i(mode_i),
    .row_load_i(row_load_i), .row_data_i(row_data_i), .scan_o(scan_o),
    .glyph_row_o(glyph_row_o), .row_adv_o(row_adv_o), .row_o(row_o)
  );

  // {mode[33:32], load data[31:24], line count[23:16], row[15:8], scan[7:4], glyph[3:0]}
  localparam logic [33:0] VEC [6] = '{
    {2'b00, 8'd10,  8'd5,  8'd12, 4'd5,  4'd0},
    {2'b01, 8'd20,  8'd9,  8'd22, 4'd9,  4'd0},
    {2'b10, 8'd30,  8'd13, 8'd31, 4'd13, 4'd5},
    {2'b11, 8'd40,  8'd35, 8'd42, 4'd3,  4'd3},
    {2'b10, 8'd254, 8'd16, 8'd0,  4'd0,  4'd0},
    {2'b00, 8'd255, 8'd7,  8'd2,  4'd7,  4'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] d);
    row_load_i = 1'b1; row_data_i = d;
    @(negedge clk_i);
    row_load_i = 1'b0;
  endtask

  task automatic do_lines(input int n);
    for (int i = 0; i < n; i++) begin
      line_end_i = 1'b1;
      @(negedge clk_i);
      line_end_i = 1'b0;
      @(negedge clk_i);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 20000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_ni = 1'b0; line_end_i = 1'b0; mode_i = 2'b00;
    row_load_i = 1'b0; row_data_i = 8'd0;
    repeat (3) @(negedge clk_i);
    check("R1 scan in reset", scan_o, 0);
    check("R1 row in reset", row_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 scan after reset", scan_o, 0);
    check("R1 row after reset", row_o, 0);
    check("R1 adv after reset", row_adv_o, 0);
    check("R1 glyph after reset", glyph_row_o, 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < 6; k++) begin
      mode_i = VEC[k][33:32];
      do_load(VEC[k][31:24]);
      do_lines(int'(VEC[k][23:16]));
      check($sformatf("R8 row vec %0d", k), row_o, VEC[k][15:8]);
      check($sformatf("R2 scan vec %0d", k), scan_o, VEC[k][7:4]);
      check($sformatf("R5/R6/R7 glyph vec %0d", k), glyph_row_o, VEC[k][3:0]);
    end

    // R3: advance visible during the strobe when scan bit 0 is one
    mode_i = 2'b00;
    do_load(8'd100);
    do_lines(1);
    line_end_i = 1'b1;
    #1 check("R3 adv at odd scan", row_adv_o, 1);
    @(negedge clk_i);
    line_end_i = 1'b0;
    check("R3 row moved", row_o, 101);

    // R4: coarse graphics, no advance at scan 1
    mode_i = 2'b01;
    do_load(8'd50);
    do_lines(1);
    line_end_i = 1'b1;
    #1 check("R4 no adv at scan 1", row_adv_o, 0);
    @(negedge clk_i);
    line_end_i = 1'b0;

    // R10: scan all ones, no strobe
    mode_i = 2'b11;
    do_load(8'd7);
    do_lines(15);
    check("R10 scan at 15", scan_o, 15);
    check("R10 adv without strobe", row_adv_o, 0);
    check("R6 glyph at 15", glyph_row_o, 15);
    mode_i = 2'b10;
    #1 check("R5 glyph fine text at 15", glyph_row_o, 7);

    // R9: load with a strobe that would advance in the same cycle
    mode_i = 2'b11;
    line_end_i = 1'b1; row_load_i = 1'b1; row_data_i = 8'd77;
    @(negedge clk_i);
    line_end_i = 1'b0; row_load_i = 1'b0;
    check("R9 row takes load", row_o, 77);
    check("R9 scan cleared", scan_o, 0);
    do_lines(2);
    check("R2 scan counts after load", scan_o, 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule